// File: doc/BRIEF.md
# Chip-Select Region Address Decoder

This block turns a 28-bit offset into an external device address and one of eight active-low chip selects. The offset is measured from a memory-mapped base. Each chip select has a 5-bit size code. Together the codes choose between two address maps:

- **Wide map.** Used when any code marks a 32 MB device. Each chip select owns a 32 MB region, eight regions cover 256 MB, and the decoder never flags an access that runs past a smaller device's window.
- **Narrow map.** Used otherwise. Each region is 16 MB. An access is checked against its device size and refused with an error if it falls outside.

A request is registered on entry. The decoded result is registered again on exit, so the answer appears two clock edges after the request is presented. The size codes are read live and must be held steady while requests are in flight.

Top module: `cs_region_decoder`

## Requirements
- R1: In the wide map, offset bits 27:25 give the index of the single chip select driven low, and `ext_addr` equals offset bits 24:0. The wide map applies when any size field (field n at `cs_cfg[5n+4:5n]`) holds 5'b00001.
- R2: In the wide map, `err` stays low for every offset, including offsets beyond the window of a smaller device on the selected chip select.
- R3: In the narrow map, offset bits 26:24 give the chip-select index, and `ext_addr` is a zero in bit 24 followed by offset bits 23:0.
- R4: In the narrow map, an offset with bit 27 set raises `err`, drives no chip select and sets `ext_addr` to zero.
- R5: In the narrow map, if offset bits 23:0 are at or above the selected device size, the access raises `err` and drives no chip select. The size codes are:

  | Code | Device size |
  |---|---|
  | 5'b11110 | 16 MB |
  | 5'b11100 | 8 MB |
  | 5'b11010 | 4 MB |
  | 5'b11000 | 2 MB |
  | 5'b10110 | 1 MB |
  | 5'b00000 | 512 bytes |

- R6: Any size code not listed in R1 or R5 is checked as a 512-byte window.
- R7: At most one chip select is low at any time. When `rsp_valid` is low, all chip selects are high, `err` is low and `ext_addr` is zero.
- R8: A request accepted at one clock edge appears on the outputs, with `rsp_valid` high, after the next edge. A single request gives a result that is valid for exactly one cycle.
- R9: During reset, `rsp_valid` and `err` are low and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_offset | input | 28 | Offset from the mapped base |
| cs_cfg | input | 40 | Eight 5-bit size codes; field n belongs to chip select n |
| rsp_valid | output | 1 | Result valid |
| cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 25 | External device address |
| err | output | 1 | Out-of-window access |

## Verification
The bench sweeps all sixteen values of offset bits 27:24, in each of three configurations, against offsets placed exactly at and just under every device-size boundary.

Each kind of fault shows up differently:
- A decoder that picks the chip select from the wrong bit field in either map lights the wrong line.
- An off-by-one in the window compare accepts the first byte past a device, or rejects its last byte.
- Flagging errors in the wide map would refuse accesses to the 1 MB and 512-byte devices that the wide map must let through.
- A design that left chip selects low between requests, or held a result for more than one cycle, fails the idle checks that follow each transaction.

// File: rtl/cs_region_decoder.sv
module cs_region_decoder #(
  parameter int ADDR_W = 28,
  parameter int NCS    = 8,
  parameter int CODE_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_offset,
  input  logic [NCS*CODE_W-1:0] cs_cfg,
  output logic                  rsp_valid,
  output logic [NCS-1:0]        cs_n,
  output logic [ADDR_W-4:0]     ext_addr,
  output logic                  err
);
  localparam int SEL_W = $clog2(NCS);
  localparam int EXT_W = ADDR_W - SEL_W;

  function automatic logic [EXT_W-1:0] win_bytes(input logic [CODE_W-1:0] code);
    case (code)
      5'b11110: win_bytes = EXT_W'(1) << 24;
      5'b11100: win_bytes = EXT_W'(1) << 23;
      5'b11010: win_bytes = EXT_W'(1) << 22;
      5'b11000: win_bytes = EXT_W'(1) << 21;
      5'b10110: win_bytes = EXT_W'(1) << 20;
      default:  win_bytes = EXT_W'(1) << 9;
    endcase
  endfunction

  logic              req_q;
  logic [ADDR_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= 1'b0;
      off_q <= '0;
    end else begin
      req_q <= req_valid;
      off_q <= req_offset;
    end

  logic [NCS-1:0] hit32;
  for (genvar i = 0; i < NCS; i++) begin : g_hit
    assign hit32[i] = cs_cfg[i*CODE_W +: CODE_W] == CODE_W'(1);
  end
  wire wide = |hit32;

  wire [SEL_W-1:0]  sel  = wide ? off_q[ADDR_W-1 -: SEL_W] : off_q[ADDR_W-2 -: SEL_W];
  wire [EXT_W-1:0]  low  = {1'b0, off_q[EXT_W-2:0]};
  wire [CODE_W-1:0] code = cs_cfg[sel*CODE_W +: CODE_W];
  wire err_c = !wide && (off_q[ADDR_W-1] || low >= win_bytes(code));
  wire take  = req_q && !err_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cs_n      <= '1;
      ext_addr  <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= req_q;
      cs_n      <= take ? ~(NCS'(1) << sel) : '1;
      ext_addr  <= take ? (wide ? off_q[EXT_W-1:0] : low) : '0;
      err       <= req_q && err_c;
    end

  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (&cs_n && !err && ext_addr == '0));
  p_err_no_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> &cs_n);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> rsp_valid);
  p_wide_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && wide) |=> !err);
endmodule

// File: tb/cs_region_decoder_bench.sv
module cs_region_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [27:0] req_offset = '0;
  logic [39:0] cs_cfg = '0;
  logic        rsp_valid, err;
  logic [7:0]  cs_n;
  logic [24:0] ext_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cs_region_decoder u_cs_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .cs_cfg(cs_cfg), .rsp_valid(rsp_valid), .cs_n(cs_n), .ext_addr(ext_addr), .err(err));

  function automatic int unsigned size_of(input logic [4:0] c);
    case (c)
      5'b11110: return 32'h100_0000;
      5'b11100: return 32'h80_0000;
      5'b11010: return 32'h40_0000;
      5'b11000: return 32'h20_0000;
      5'b10110: return 32'h10_0000;
      default:  return 32'h200;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [27:0] off);
    logic wide, e;
    int   cs;
    logic [7:0]  ecs;
    logic [24:0] ea;
    wide = 0;
    for (int i = 0; i < 8; i++) if (cs_cfg[i*5 +: 5] == 5'b00001) wide = 1;
    e = 0; ea = '0; ecs = 8'hFF;
    if (wide) begin
      cs = int'(off[27:25]);
      ea = off[24:0];
    end else begin
      cs = int'(off[26:24]);
      if (off[27] || ({8'd0, off[23:0]} >= size_of(cs_cfg[cs*5 +: 5]))) e = 1;
      else ea = {1'b0, off[23:0]};
    end
    if (!e) ecs = ~(8'd1 << cs);
    @(negedge clk); req_valid = 1; req_offset = off;
    @(negedge clk); req_valid = 0; req_offset = ~off;
    chk("R8 early", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    chk("R8 valid", {63'd0, rsp_valid}, 64'd1);
    chk(wide ? "R1 cs" : (off[27] ? "R4 cs" : "R3/R5/R6 cs"), {56'd0, cs_n}, {56'd0, ecs});
    chk(wide ? "R1 addr" : "R3/R4 addr", {39'd0, ext_addr}, {39'd0, ea});
    chk(wide ? "R2 err" : (off[27] ? "R4 err" : "R5/R6 err"), {63'd0, err}, {63'd0, e});
    @(negedge clk);
    chk("R7 idle", {29'd0, rsp_valid, err, cs_n, ext_addr}, {29'd0, 1'b0, 1'b0, 8'hFF, 25'd0});
  endtask

  task automatic sweep();
    int unsigned pts[12] = '{0, 32'h1FF, 32'h200, 32'hFFFFF, 32'h100000, 32'h1FFFFF,
                             32'h200000, 32'h3FFFFF, 32'h400000, 32'h7FFFFF,
                             32'h800000, 32'hFFFFFF};
    for (int r = 0; r < 16; r++)
      for (int p = 0; p < 12; p++)
        txn({r[3:0], pts[p][23:0]});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", {54'd0, rsp_valid, err, cs_n}, {54'd0, 1'b0, 1'b0, 8'hFF});
    rst_n = 1;
    @(negedge clk);
    // all 16 MB: narrow map, R3 and R4
    cs_cfg = {8{5'b11110}};
    sweep();
    // mixed sizes plus one unlisted code: R5, R6
    cs_cfg = {5'b11110, 5'b10101, 5'b00000, 5'b10110, 5'b11000, 5'b11010, 5'b11100, 5'b11110};
    sweep();
    // one 32 MB device among small ones: wide map, R1, R2
    cs_cfg = {5'b00000, 5'b10110, 5'b11000, 5'b00001, 5'b11010, 5'b11100, 5'b11110, 5'b10101};
    sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule